// File: doc/BRIEF.md
# Dual-Clock Interrupting Message Mailbox

The mailbox carries 64-bit messages from a producer running on one clock to a host running on another. On the producer side, a write strobe arrives with an address and a 64-bit payload. When the address matches the mailbox address, the payload is queued in an internal FIFO. The FIFO crosses clock domains by passing Gray-coded pointers through two-flop synchronizers. Each domain has its own asynchronous active-low reset.

On the host side, a select input chooses what the read port returns: the low half of the oldest message, the high half of the oldest message, or a 32-bit status word. A read strobe on the high half removes the message from the queue, so software reads the low word first and the high word second.

Two outputs go back to the system:
- A wait output tells the producer to stop sending once the queue reaches a programmable level. The block applies back-pressure instead of silently losing data.
- An interrupt output is raised while the queue is full. It is also raised while the queue holds data, but only when the interrupt-enable input is set.

Top module: `msg_mailbox`

## Requirements
- R1: A write strobe whose address equals `MBOX_ADDR` and that arrives while the FIFO is not full stores its 64-bit payload. Messages are returned in arrival order. With `rd_sel`=0, `rd_data` shows bits 31:0 of the oldest message. With `rd_sel`=1, it shows bits 63:32.
- R2: A write strobe with any other address leaves the FIFO contents and occupancy unchanged.
- R3: A write that arrives while the FIFO holds `2**AW` messages is dropped. Occupancy never exceeds `2**AW`.
- R4: A read strobe with `rd_sel`=1 while the FIFO is empty does not move the read pointer. The next message written is the next message read.
- R5: A read strobe with `rd_sel`=0 never removes a message. Only a read strobe with `rd_sel`=1 on a non-empty FIFO removes one.
- R6: With `rd_sel`=2, `rd_data` is the status word. Its fields are:
  - bit 0: not-empty
  - bit 1: full
  - bit 2: occupancy >= `PFULL_LEVEL`
  - bits 31:16: occupancy as seen from the read domain
  - all other bits: zero.
  With `rd_sel`=3, `rd_data` is zero.
- R7: `wr_wait` is high exactly while the write-domain occupancy is at least `PFULL_LEVEL`. The default for `PFULL_LEVEL` is `2**AW - 4`.
- R8: `irq` equals (`irq_en` AND not-empty) OR full, using the read-domain view.
- R9: After reset, the status word is zero, and both `irq` and `wr_wait` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address, compared with MBOX_ADDR |
| wr_data | input | MSG_W | Message payload |
| wr_wait | output | 1 | Back-pressure to the producer, high at or above PFULL_LEVEL |
| rd_clk | input | 1 | Host clock |
| rd_rst_n | input | 1 | Host-domain asynchronous reset, active low |
| rd_en | input | 1 | Read strobe; pops when rd_sel selects the high half |
| rd_sel | input | 2 | 0 low half, 1 high half, 2 status, 3 zero |
| rd_data | output | 32 | Selected read word |
| irq_en | input | 1 | Enables the not-empty interrupt source |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench sweeps the fill level over every value from zero to two past capacity. At each level it checks the status word, `wr_wait` and `irq` with both settings of `irq_en`. This separates the not-empty, programmable-full and full thresholds from one another and shows that writes beyond capacity are dropped.

Every message carries a payload derived from its fill round and index. Draining the queue and comparing both halves of each message therefore catches ordering errors, half-swaps and lost entries.

Three further patterns probe the read side and the address filter:
- Repeated low-word reads show that only a high-word read pops.
- A high-word read on an empty queue, followed by one new message, shows that the pointer did not slip.
- Writes to a foreign address show that the address filter works.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } mbox_sel_e;

  // Status word: [0] not-empty, [1] full, [2] level reached, [31:16] count
  function automatic logic [31:0] pack_status(input logic ne, input logic fl,
                                              input logic pf, input logic [15:0] cnt);
    return {cnt, 13'd0, pf, fl, ne};
  endfunction

endpackage

// File: rtl/mbox_ptr_xing.sv
module mbox_ptr_xing #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out = gray_to_bin(sync_q);

endmodule

// File: rtl/mbox_wr_ctl.sv
module mbox_wr_ctl #(
  parameter int AW          = 4,
  parameter int PFULL_LEVEL = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic [AW:0] rptr_sync,
  output logic [AW:0] wptr_bin,
  output logic [AW:0] wptr_gray,
  output logic [AW:0] count,
  output logic        full,
  output logic        pfull,
  output logic        push
);

  localparam int          PW      = AW + 1;
  localparam logic [AW:0] DEPTH_P = PW'(1 << AW);
  localparam logic [AW:0] PF_P    = PW'(PFULL_LEVEL);

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  assign count = wptr_bin - rptr_sync;
  assign full  = (count == DEPTH_P);
  assign pfull = (count >= PF_P);
  assign push  = push_req && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (push) begin
      wptr_bin  <= wptr_bin + 1'b1;
      wptr_gray <= bin_to_gray(wptr_bin + 1'b1);
    end
  end

endmodule

// File: rtl/mbox_rd_ctl.sv
module mbox_rd_ctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pop_req,
  input  logic [AW:0] wptr_sync,
  output logic [AW:0] rptr_bin,
  output logic [AW:0] rptr_gray,
  output logic [AW:0] count,
  output logic        empty,
  output logic        pop
);

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  assign count = wptr_sync - rptr_bin;
  assign empty = (count == '0);
  assign pop   = pop_req && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else if (pop) begin
      rptr_bin  <= rptr_bin + 1'b1;
      rptr_gray <= bin_to_gray(rptr_bin + 1'b1);
    end
  end

endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int                AW          = 4,
  parameter int                MSG_W       = 64,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MBOX_ADDR   = 8'h40,
  parameter int                PFULL_LEVEL = (1 << AW) - 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MSG_W-1:0]  wr_data,
  output logic              wr_wait,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              irq_en,
  output logic              irq
);

  localparam int          DEPTH   = 1 << AW;
  localparam int          PW      = AW + 1;
  localparam int          HALF    = MSG_W / 2;
  localparam logic [AW:0] DEPTH_P = PW'(DEPTH);
  localparam logic [AW:0] PF_P    = PW'(PFULL_LEVEL);

  // Named internal events for the checker
  logic          wr_push, wr_full, rd_pop, rd_empty, rd_full;
  logic [AW:0]   wr_ptr_bin, wr_ptr_gray, wr_count, wr_rptr_sync;
  logic [AW:0]   rd_ptr_bin, rd_ptr_gray, rd_count, rd_wptr_sync;
  logic          wr_pfull, rd_pfull;
  logic [MSG_W-1:0] mem [DEPTH];
  logic [MSG_W-1:0] head;
  mbox_sel_e     sel;

  mbox_wr_ctl #(.AW(AW), .PFULL_LEVEL(PFULL_LEVEL)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .push_req(wr_valid && (wr_addr == MBOX_ADDR)),
    .rptr_sync(wr_rptr_sync),
    .wptr_bin(wr_ptr_bin), .wptr_gray(wr_ptr_gray), .count(wr_count),
    .full(wr_full), .pfull(wr_pfull), .push(wr_push)
  );

  mbox_ptr_xing #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rd_ptr_gray), .bin_out(wr_rptr_sync)
  );

  mbox_ptr_xing #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wr_ptr_gray), .bin_out(rd_wptr_sync)
  );

  mbox_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .pop_req(rd_en && (sel == SEL_HI)),
    .wptr_sync(rd_wptr_sync),
    .rptr_bin(rd_ptr_bin), .rptr_gray(rd_ptr_gray), .count(rd_count),
    .empty(rd_empty), .pop(rd_pop)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[wr_ptr_bin[AW-1:0]] <= wr_data;
  end

  assign head     = mem[rd_ptr_bin[AW-1:0]];
  assign sel      = mbox_sel_e'(rd_sel);
  assign rd_full  = (rd_count == DEPTH_P);
  assign rd_pfull = (rd_count >= PF_P);
  assign wr_wait  = wr_pfull;
  assign irq      = (irq_en && !rd_empty) || rd_full;

  always_comb begin
    case (sel)
      SEL_LO:   rd_data = head[HALF-1:0];
      SEL_HI:   rd_data = head[MSG_W-1:HALF];
      SEL_STAT: rd_data = pack_status(!rd_empty, rd_full, rd_pfull, 16'(rd_count));
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int PW          = 5,
  parameter int PFULL_LEVEL = 12
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_valid,
  input logic          wr_full,
  input logic [PW-1:0] wr_count,
  input logic [PW-1:0] wr_ptr,
  input logic          wr_wait,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic          rd_empty,
  input logic          rd_full,
  input logic [PW-1:0] rd_count,
  input logic [PW-1:0] rd_ptr,
  input logic          irq_en,
  input logic          irq
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1 << (PW - 1));
  localparam logic [PW-1:0] PF_P    = PW'(PFULL_LEVEL);

  // R3: a strobe seen while full leaves the write pointer in place
  p_full_blocks_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && wr_full) |=> $stable(wr_ptr));

  // R3: occupancy bounded in both domains
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_count <= DEPTH_P);
  p_rd_bound_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_count <= DEPTH_P);

  // R4: high-word read on empty FIFO does not move the read pointer
  p_empty_blocks_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_sel == 2'd1 && rd_empty) |=> $stable(rd_ptr));

  // R5: a low-word read never pops
  p_lo_no_pop_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_sel == 2'd0) |=> $stable(rd_ptr));

  // R7: back-pressure at the programmable level
  p_wait_level_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_count >= PF_P) |-> wr_wait);

  // R8: full always interrupts; disabled and empty never does
  p_irq_full_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_full |-> irq);
  p_irq_quiet_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!irq_en && rd_empty) |-> !irq);

endmodule

bind msg_mailbox mbox_checker #(.PW(PW), .PFULL_LEVEL(PFULL_LEVEL)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_valid(wr_valid && (wr_addr == MBOX_ADDR)), .wr_full(wr_full),
  .wr_count(wr_count), .wr_ptr(wr_ptr_bin), .wr_wait(wr_wait),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_empty(rd_empty), .rd_full(rd_full),
  .rd_count(rd_count), .rd_ptr(rd_ptr_bin), .irq_en(irq_en), .irq(irq)
);

// File: tb/msg_mailbox_tb_top.sv
module msg_mailbox_tb_top;

  localparam int          AW    = 3;
  localparam int          DEPTH = 1 << AW;
  localparam int          PF    = DEPTH - 4;
  localparam logic [7:0]  ADDR  = 8'h5A;

  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        wr_valid = 0;
  logic [7:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        wr_wait;
  logic        rd_en = 0;
  logic [1:0]  rd_sel = 2'd2;
  logic [31:0] rd_data;
  logic        irq_en = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3 rd_clk = ~rd_clk;   // second, unrelated clock

  msg_mailbox #(.AW(AW), .MSG_W(64), .ADDR_W(8), .MBOX_ADDR(ADDR)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_wait(wr_wait), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
  );

  function automatic logic [63:0] payload(int round, int idx);
    logic [31:0] hi, lo;
    hi = 32'hC0DE_0000 + 32'(round * 16 + idx);
    lo = 32'h1234_5678 ^ 32'(idx * 7 + round * 131);
    return {hi, lo};
  endfunction

  function automatic logic [31:0] exp_status(int n);
    logic [31:0] s;
    s = 32'(n) << 16;
    if (n > 0)     s = s | 32'd1;
    if (n == DEPTH) s = s | 32'd2;
    if (n >= PF)   s = s | 32'd4;
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
  endtask

  task automatic write_msg(logic [7:0] a, logic [63:0] d);
    @(negedge wr_clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic peek(logic [1:0] s, output logic [31:0] v);
    @(negedge rd_clk);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic read_msg(output logic [63:0] m);
    @(negedge rd_clk);
    rd_sel = 2'd0;
    #1 m[31:0] = rd_data;
    rd_sel = 2'd1;
    #1 m[63:32] = rd_data;
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    rd_sel = 2'd2;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] m;
    irq_en = 1;
    repeat (3) @(posedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
    // R9 reset state
    peek(2'd2, v); check("R9 status", v, 32'd0);
    check("R9 irq", {31'd0, irq}, 32'd0);
    check("R9 wr_wait", {31'd0, wr_wait}, 32'd0);
    peek(2'd3, v); check("R6 unused select", v, 32'd0);

    // Sweep fill level 0 .. DEPTH+2 (R1, R3, R6, R7, R8)
    for (int n = 0; n <= DEPTH + 2; n++) begin
      int stored;
      stored = (n > DEPTH) ? DEPTH : n;
      for (int k = 0; k < n; k++) write_msg(ADDR, payload(n, k));
      settle();
      peek(2'd2, v); check("R6 status fill", v, exp_status(stored));
      check("R7 wr_wait", {31'd0, wr_wait}, {31'd0, stored >= PF});
      @(negedge rd_clk); irq_en = 0; #1;
      check("R8 irq disabled", {31'd0, irq}, {31'd0, stored == DEPTH});
      irq_en = 1; #1;
      check("R8 irq enabled", {31'd0, irq}, {31'd0, stored > 0});
      // R5: low-word reads with strobe do not pop
      repeat (3) begin
        @(negedge rd_clk); rd_sel = 2'd0; rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
      end
      peek(2'd2, v); check("R5 low read keeps count", v, exp_status(stored));
      // R1/R3: drain in order; overflow writes were dropped
      for (int k = 0; k < stored; k++) begin
        read_msg(m);
        check("R1 low word", m[31:0], payload(n, k)  & 64'hFFFF_FFFF);
        check("R1 high word", m[63:32], payload(n, k) >> 32);
      end
      settle();
      peek(2'd2, v); check("R3 empty after drain", v, 32'd0);
      check("R7 wait released", {31'd0, wr_wait}, 32'd0);
    end

    // R4: pop attempt on empty, then one message must read back intact
    read_msg(m);
    read_msg(m);
    settle();
    peek(2'd2, v); check("R4 status after empty pops", v, 32'd0);
    write_msg(ADDR, payload(99, 1));
    settle();
    read_msg(m);
    check("R4 next low", m[31:0], payload(99, 1) & 64'hFFFF_FFFF);
    check("R4 next high", m[63:32], payload(99, 1) >> 32);

    // R2: foreign addresses ignored
    write_msg(ADDR ^ 8'h01, payload(7, 7));
    write_msg(8'h00, payload(7, 8));
    write_msg(ADDR, payload(7, 9));
    write_msg(ADDR ^ 8'h80, payload(7, 10));
    settle();
    peek(2'd2, v); check("R2 only matching stored", v, exp_status(1));
    read_msg(m);
    check("R2 stored payload low", m[31:0], payload(7, 9) & 64'hFFFF_FFFF);
    check("R2 stored payload high", m[63:32], payload(7, 9) >> 32);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule